// File: doc/BRIEF.md
# Registered Command Buffer with Even-Parity Guard

This block sits between a memory controller and the DRAM devices of a registered module. On each rising clock edge it takes in the row/column address, the bank address, the three active-low command strobes, the chip selects and one parity bit. One clock later it presents the same command on its DRAM-side outputs. The block checks the parity of every command it captures and reports a failure on an active-low error line that stays low for a fixed two-cycle window.

The same command bus also writes a small bank of 4-bit configuration words held inside the block. A configuration write needs all chip selects and all three strobes low at the same time. The block takes the word index and the data from fixed address and bank bits. A bad parity bit never stops a DRAM command: the command goes out anyway. A bad parity bit does stop a configuration write: the write is dropped and the stored word keeps its old value. The stored words can be read on a flat output vector.

Top module: `cmd_parity_register`

## Requirements
- R1: The values of addr_i, bank_i, ras_n_i, cas_n_i, we_n_i and cs_n_i captured at a rising edge appear unchanged on the matching outputs right after that edge. They stay there until the next edge.
- R2: A captured command has good parity when the count of ones across addr_i[15:0], bank_i[2:0], ras_n_i, cas_n_i, we_n_i and par_i is even. An odd count is a parity failure.
- R3: For a selected command with a parity failure, err_n_o goes low at the edge after the one that captured the command and stays low for exactly two cycles. A further failure inside that window starts a fresh two-cycle window.
- R4: A cycle in which every cs_n_i bit is high never causes err_n_o to go low, whatever its parity.
- R5: A selected DRAM command with a parity failure is still forwarded unchanged on the registered outputs.
- R6: A configuration write is a captured command with every cs_n_i bit low and ras_n_i, cas_n_i and we_n_i all low. The word index is {bank_i[2:0], addr_i[4:3]} and the data is {bank_i[2], addr_i[2:0]}. Word k shows on cfg_words_o[4k+3:4k] from the edge after the one that captured the write.
- R7: A configuration write with a parity failure leaves every configuration word unchanged. It still raises the error window of R3.
- R8: With only some chip selects low and all three strobes low, the command is an ordinary DRAM command. No configuration word changes.
- R9: A rising edge with rst_n low clears all configuration words to zero and sets err_n_o high. It also drives the registered outputs to the idle encoding: address 0, bank 0, all strobes high and all chip selects high.

Reading the requirements together:
- A selected command is one with at least one cs_n_i bit low.
- The two-cycle error window in R3 applies to all selected commands, DRAM commands and configuration writes alike.
- R6 and R7 differ only in parity: a good write updates the word, a bad write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all capture happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| addr_i | input | 16 | Address from the controller |
| bank_i | input | 3 | Bank address from the controller |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write strobe, active low |
| cs_n_i | input | 2 | Chip selects, active low |
| par_i | input | 1 | Even-parity bit for address, bank and strobes |
| addr_o | output | 16 | Registered address to the DRAM side |
| bank_o | output | 3 | Registered bank address |
| ras_n_o | output | 1 | Registered row strobe |
| cas_n_o | output | 1 | Registered column strobe |
| we_n_o | output | 1 | Registered write strobe |
| cs_n_o | output | 2 | Registered chip selects |
| err_n_o | output | 1 | Parity failure flag, active low, two-cycle window |
| cfg_words_o | output | 128 | All configuration words, word k at bits [4k+3:4k] |

## Verification
Two things can happen in the same cycle: a configuration write commits while the error window from the command just before it is still open. The bench provokes this by sending a bad-parity DRAM command and then, on the very next cycle, a good configuration write. It also sends a bad write straight after a bad command so that the window restarts. A scoreboard model predicts, edge by edge, the word contents and the error line. It checks both in the same cycle, so a write that the previous failure blocks, or a window that the write closes, shows up as a mismatch.

// File: rtl/cmdpar_pkg.sv
`timescale 1ns/1ps
package cmdpar_pkg;

   // Classification of a registered command
   typedef enum logic [1:0] {
      KIND_DESEL  = 2'd0,
      KIND_DRAM   = 2'd1,
      KIND_CFG_WR = 2'd2
   } cmd_kind_e;

   // Idle level of the active-low strobes and selects
   localparam logic STROBE_IDLE = 1'b1;

   // Address bits consumed by the word index above the data field
   localparam int unsigned IDX_ADDR_BITS = 2;

endpackage

// File: rtl/cmdpar_capture.sv
`timescale 1ns/1ps
module cmdpar_capture #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BANK_W = 3,
   parameter int unsigned CS_W   = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BANK_W-1:0] bank_i,
   input  logic              ras_n_i,
   input  logic              cas_n_i,
   input  logic              we_n_i,
   input  logic [CS_W-1:0]   cs_n_i,
   input  logic              par_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic [BANK_W-1:0] bank_q,
   output logic              ras_n_q,
   output logic              cas_n_q,
   output logic              we_n_q,
   output logic [CS_W-1:0]   cs_n_q,
   output logic              par_q
);
   import cmdpar_pkg::*;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         bank_q  <= '0;
         ras_n_q <= STROBE_IDLE;
         cas_n_q <= STROBE_IDLE;
         we_n_q  <= STROBE_IDLE;
         cs_n_q  <= {CS_W{STROBE_IDLE}};
         par_q   <= 1'b0;
      end else begin
         addr_q  <= addr_i;
         bank_q  <= bank_i;
         ras_n_q <= ras_n_i;
         cas_n_q <= cas_n_i;
         we_n_q  <= we_n_i;
         cs_n_q  <= cs_n_i;
         par_q   <= par_i;
      end
   end

endmodule

// File: rtl/cmdpar_parity.sv
`timescale 1ns/1ps
module cmdpar_parity #(
   parameter int unsigned N    = 23,
   parameter bit          TREE = 1'b1
) (
   input  logic [N-1:0] bits_i,
   output logic         odd_o
);

   generate
      if (N < 2) begin : g_bad_n
         $error("cmdpar_parity: N must be at least 2");
      end

      if (TREE) begin : g_tree
         assign odd_o = ^bits_i;
      end else begin : g_chain
         logic [N:0] acc;
         assign acc[0] = 1'b0;
         for (genvar g = 0; g < N; g++) begin : g_link
            assign acc[g+1] = acc[g] ^ bits_i[g];
         end
         assign odd_o = acc[N];
      end
   endgenerate

endmodule

// File: rtl/cmdpar_err_hold.sv
`timescale 1ns/1ps
module cmdpar_err_hold #(
   parameter int unsigned HOLD = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fail_i,
   output logic err_n_o
);
   localparam int unsigned CW = $clog2(HOLD + 1);
   localparam logic [CW-1:0] LOAD = CW'(HOLD);

   logic [CW-1:0] cnt;

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("cmdpar_err_hold: HOLD must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (fail_i) begin
         cnt <= LOAD;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign err_n_o = (cnt == '0);

endmodule

// File: rtl/cmdpar_cfg_bank.sv
`timescale 1ns/1ps
module cmdpar_cfg_bank #(
   parameter int unsigned IDX_W  = 5,
   parameter int unsigned WORD_W = 4
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en_i,
   input  logic [IDX_W-1:0]                idx_i,
   input  logic [WORD_W-1:0]               data_i,
   output logic [(1<<IDX_W)*WORD_W-1:0]    words_o
);
   localparam int unsigned NUM_WORDS = 1 << IDX_W;

   generate
      for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
         logic [WORD_W-1:0] word_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               word_q <= '0;
            end else if (wr_en_i && (idx_i == IDX_W'(w))) begin
               word_q <= data_i;
            end
         end
         assign words_o[w*WORD_W +: WORD_W] = word_q;
      end
   endgenerate

endmodule

// File: rtl/cmd_parity_register.sv
`timescale 1ns/1ps
module cmd_parity_register #(
   parameter int unsigned ADDR_W   = 16,
   parameter int unsigned BANK_W   = 3,
   parameter int unsigned CS_W     = 2,
   parameter int unsigned WORD_W   = 4,
   parameter int unsigned ERR_HOLD = 2,
   parameter bit          PAR_TREE = 1'b1
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [ADDR_W-1:0]                        addr_i,
   input  logic [BANK_W-1:0]                        bank_i,
   input  logic                                     ras_n_i,
   input  logic                                     cas_n_i,
   input  logic                                     we_n_i,
   input  logic [CS_W-1:0]                          cs_n_i,
   input  logic                                     par_i,
   output logic [ADDR_W-1:0]                        addr_o,
   output logic [BANK_W-1:0]                        bank_o,
   output logic                                     ras_n_o,
   output logic                                     cas_n_o,
   output logic                                     we_n_o,
   output logic [CS_W-1:0]                          cs_n_o,
   output logic                                     err_n_o,
   output logic [(1<<(BANK_W+2))*WORD_W-1:0]        cfg_words_o
);
   import cmdpar_pkg::*;

   localparam int unsigned IDX_W     = BANK_W + IDX_ADDR_BITS;
   localparam int unsigned PAR_N     = ADDR_W + BANK_W + 4;
   localparam int unsigned DATA_ABIT = WORD_W - 1;

   generate
      if (ADDR_W < DATA_ABIT + IDX_ADDR_BITS) begin : g_bad_addr
         $error("cmd_parity_register: ADDR_W too small for index and data fields");
      end
      if (WORD_W < 2 || WORD_W > 4) begin : g_bad_word
         $error("cmd_parity_register: WORD_W must be 2..4");
      end
      if (CS_W < 1 || BANK_W < 1) begin : g_bad_sel
         $error("cmd_parity_register: CS_W and BANK_W must be at least 1");
      end
      if (ERR_HOLD < 2) begin : g_bad_hold
         $error("cmd_parity_register: ERR_HOLD must be at least 2");
      end
   endgenerate

   logic par_q;
   logic odd;
   cmd_kind_e kind;
   logic fail;
   logic wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [WORD_W-1:0] wr_data;

   cmdpar_capture #(
      .ADDR_W (ADDR_W),
      .BANK_W (BANK_W),
      .CS_W   (CS_W)
   ) i_capture (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr_i  (addr_i),
      .bank_i  (bank_i),
      .ras_n_i (ras_n_i),
      .cas_n_i (cas_n_i),
      .we_n_i  (we_n_i),
      .cs_n_i  (cs_n_i),
      .par_i   (par_i),
      .addr_q  (addr_o),
      .bank_q  (bank_o),
      .ras_n_q (ras_n_o),
      .cas_n_q (cas_n_o),
      .we_n_q  (we_n_o),
      .cs_n_q  (cs_n_o),
      .par_q   (par_q)
   );

   cmdpar_parity #(
      .N    (PAR_N),
      .TREE (PAR_TREE)
   ) i_parity (
      .bits_i ({addr_o, bank_o, ras_n_o, cas_n_o, we_n_o, par_q}),
      .odd_o  (odd)
   );

   always_comb begin
      if (&cs_n_o) begin
         kind = KIND_DESEL;
      end else if ((cs_n_o == '0) && !ras_n_o && !cas_n_o && !we_n_o) begin
         kind = KIND_CFG_WR;
      end else begin
         kind = KIND_DRAM;
      end
   end

   assign fail    = (kind != KIND_DESEL) && odd;
   assign wr_en   = (kind == KIND_CFG_WR) && !odd;
   assign wr_idx  = {bank_o, addr_o[DATA_ABIT +: IDX_ADDR_BITS]};
   assign wr_data = {bank_o[BANK_W-1], addr_o[DATA_ABIT-1:0]};

   cmdpar_err_hold #(
      .HOLD (ERR_HOLD)
   ) i_err_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .fail_i  (fail),
      .err_n_o (err_n_o)
   );

   cmdpar_cfg_bank #(
      .IDX_W  (IDX_W),
      .WORD_W (WORD_W)
   ) i_cfg_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en_i (wr_en),
      .idx_i   (wr_idx),
      .data_i  (wr_data),
      .words_o (cfg_words_o)
   );

endmodule

// File: rtl/cmdpar_chk.sv
`timescale 1ns/1ps
module cmdpar_chk #(
   parameter int unsigned ADDR_W = 16,
   parameter int unsigned BANK_W = 3,
   parameter int unsigned CS_W   = 2,
   parameter int unsigned WORD_W = 4
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [ADDR_W-1:0]                  addr_i,
   input logic [BANK_W-1:0]                  bank_i,
   input logic                               ras_n_i,
   input logic                               cas_n_i,
   input logic                               we_n_i,
   input logic [CS_W-1:0]                    cs_n_i,
   input logic                               par_i,
   input logic [ADDR_W-1:0]                  addr_o,
   input logic [BANK_W-1:0]                  bank_o,
   input logic                               ras_n_o,
   input logic                               cas_n_o,
   input logic                               we_n_o,
   input logic [CS_W-1:0]                    cs_n_o,
   input logic                               err_n_o,
   input logic [(1<<(BANK_W+2))*WORD_W-1:0]  cfg_words_o
);

   logic in_odd;
   logic in_cfg_wr;
   assign in_odd    = ^{addr_i, bank_i, ras_n_i, cas_n_i, we_n_i, par_i};
   assign in_cfg_wr = (cs_n_i == '0) && !ras_n_i && !cas_n_i && !we_n_i;

   // R1
   fwd_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (addr_o == $past(addr_i)) && (bank_o == $past(bank_i)) &&
               (ras_n_o == $past(ras_n_i)) && (cas_n_o == $past(cas_n_i)) &&
               (we_n_o == $past(we_n_i)) && (cs_n_o == $past(cs_n_i)));

   // R3
   err_two_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_n_o) |=> !err_n_o);

   // R3
   err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!(&cs_n_i) && in_odd) |=> ##1 !err_n_o);

   // R4
   desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&cs_n_i) ##1 err_n_o |=> err_n_o);

   // R7
   bad_wr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_cfg_wr && in_odd) |=> ##1 $stable(cfg_words_o));

   // R9
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |=> err_n_o && (cfg_words_o == '0) && (addr_o == '0) &&
                 (bank_o == '0) && ras_n_o && cas_n_o && we_n_o && (&cs_n_o));

endmodule

bind cmd_parity_register cmdpar_chk #(
   .ADDR_W (ADDR_W),
   .BANK_W (BANK_W),
   .CS_W   (CS_W),
   .WORD_W (WORD_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .addr_i      (addr_i),
   .bank_i      (bank_i),
   .ras_n_i     (ras_n_i),
   .cas_n_i     (cas_n_i),
   .we_n_i      (we_n_i),
   .cs_n_i      (cs_n_i),
   .par_i       (par_i),
   .addr_o      (addr_o),
   .bank_o      (bank_o),
   .ras_n_o     (ras_n_o),
   .cas_n_o     (cas_n_o),
   .we_n_o      (we_n_o),
   .cs_n_o      (cs_n_o),
   .err_n_o     (err_n_o),
   .cfg_words_o (cfg_words_o)
);

// File: tb/test_cmd_parity_register.sv
`timescale 1ns/1ps
module test_cmd_parity_register;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [15:0]  addr_i = '0;
   logic [2:0]   bank_i = '0;
   logic         ras_n_i = 1'b1;
   logic         cas_n_i = 1'b1;
   logic         we_n_i = 1'b1;
   logic [1:0]   cs_n_i = 2'b11;
   logic         par_i = 1'b0;
   logic [15:0]  addr_o;
   logic [2:0]   bank_o;
   logic         ras_n_o, cas_n_o, we_n_o;
   logic [1:0]   cs_n_o;
   logic         err_n_o;
   logic [127:0] cfg_words_o;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #2.5 clk = ~clk;

   cmd_parity_register i_cmd_parity_register (
      .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .bank_i(bank_i),
      .ras_n_i(ras_n_i), .cas_n_i(cas_n_i), .we_n_i(we_n_i), .cs_n_i(cs_n_i),
      .par_i(par_i), .addr_o(addr_o), .bank_o(bank_o), .ras_n_o(ras_n_o),
      .cas_n_o(cas_n_o), .we_n_o(we_n_o), .cs_n_o(cs_n_o), .err_n_o(err_n_o),
      .cfg_words_o(cfg_words_o)
   );

   typedef struct {
      logic [15:0]  a;
      logic [2:0]   ba;
      logic [2:0]   rcw;
      logic [1:0]   cs;
      logic         err_n;
      logic [127:0] cfg;
      string        tag;
   } exp_t;

   exp_t exp_q[$];

   // model state: what the design has registered, per the requirements
   logic [15:0]  m_a   = '0;
   logic [2:0]   m_ba  = '0;
   logic [2:0]   m_rcw = 3'b111;
   logic [1:0]   m_cs  = 2'b11;
   logic         m_par = 1'b0;
   int           m_cnt = 0;
   logic [127:0] m_cfg = '0;

   function automatic logic good_par(input logic [15:0] a, input logic [2:0] ba,
                                     input logic [2:0] rcw);
      return ^{a, ba, rcw};
   endfunction

   task automatic step(input logic rst, input logic [15:0] a, input logic [2:0] ba,
                       input logic [2:0] rcw, input logic [1:0] cs,
                       input logic bad, input string tag);
      logic odd_q;
      exp_t e;
      @(negedge clk);
      rst_n   = rst;
      addr_i  = a;
      bank_i  = ba;
      {ras_n_i, cas_n_i, we_n_i} = rcw;
      cs_n_i  = cs;
      par_i   = good_par(a, ba, rcw) ^ bad;
      // advance model across the coming edge
      odd_q = ^{m_a, m_ba, m_rcw, m_par};
      if (!rst) begin
         m_cnt = 0; m_cfg = '0;
         m_a = '0; m_ba = '0; m_rcw = 3'b111; m_cs = 2'b11; m_par = 1'b0;
      end else begin
         if ((m_cs != 2'b11) && odd_q) m_cnt = 2;
         else if (m_cnt > 0) m_cnt = m_cnt - 1;
         if ((m_cs == 2'b00) && (m_rcw == 3'b000) && !odd_q)
            m_cfg[{m_ba, m_a[4:3]}*4 +: 4] = {m_ba[2], m_a[2:0]};
         m_a = a; m_ba = ba; m_rcw = rcw; m_cs = cs; m_par = par_i;
      end
      e.a = m_a; e.ba = m_ba; e.rcw = m_rcw; e.cs = m_cs;
      e.err_n = (m_cnt == 0); e.cfg = m_cfg; e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input logic bad, input string tag);
      step(1'b1, 16'h0000, 3'd0, 3'b111, 2'b11, bad, tag);
   endtask

   // monitor / scoreboard
   initial begin
      exp_t e;
      forever begin
         @(posedge clk);
         #1;
         if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            n_checks++;
            if ({addr_o, bank_o, ras_n_o, cas_n_o, we_n_o, cs_n_o} !==
                {e.a, e.ba, e.rcw, e.cs}) begin
               n_fail++;
               $display("FAIL %s cmd out: actual a=%h ba=%h rcw=%b cs=%b expected a=%h ba=%h rcw=%b cs=%b",
                        e.tag, addr_o, bank_o, {ras_n_o, cas_n_o, we_n_o}, cs_n_o,
                        e.a, e.ba, e.rcw, e.cs);
            end
            n_checks++;
            if (err_n_o !== e.err_n) begin
               n_fail++;
               $display("FAIL %s err_n: actual %b expected %b", e.tag, err_n_o, e.err_n);
            end
            n_checks++;
            if (cfg_words_o !== e.cfg) begin
               n_fail++;
               $display("FAIL %s cfg words: actual %h expected %h", e.tag, cfg_words_o, e.cfg);
            end
         end
      end
   end

   // watchdog
   initial begin
      #(200000 * 5);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      // R9: reset state
      step(1'b0, 16'h0000, 3'd0, 3'b111, 2'b11, 1'b0, "R9");
      step(1'b0, 16'hBEEF, 3'd6, 3'b000, 2'b00, 1'b1, "R9");
      // R4: deselected, quiet
      idle(1'b0, "R4");
      // R1: ordinary commands with good parity, several patterns
      step(1'b1, 16'h1234, 3'd5, 3'b101, 2'b10, 1'b0, "R1");
      step(1'b1, 16'h00A5, 3'd2, 3'b011, 2'b00, 1'b0, "R1");
      // R2: many ones, parity bit set to make it even
      step(1'b1, 16'hFFFE, 3'd7, 3'b110, 2'b01, 1'b0, "R2");
      // R8: one select low, all strobes low, good parity -> no write to word 31
      step(1'b1, 16'h001F, 3'd7, 3'b000, 2'b01, 1'b0, "R8");
      idle(1'b0, "R8");
      // R5: bad parity DRAM command forwarded, R3: two-cycle window
      step(1'b1, 16'h8001, 3'd1, 3'b100, 2'b10, 1'b1, "R5");
      idle(1'b0, "R3");
      idle(1'b0, "R3");
      idle(1'b0, "R3");
      // R4: deselected with bad parity never raises error
      idle(1'b1, "R4");
      idle(1'b1, "R4");
      idle(1'b1, "R4");
      // R6: good configuration writes, words 0, 31 and 13
      step(1'b1, 16'h0005, 3'd0, 3'b000, 2'b00, 1'b0, "R6");
      step(1'b1, 16'h001A, 3'd7, 3'b000, 2'b00, 1'b0, "R6");
      step(1'b1, 16'h000F, 3'd3, 3'b000, 2'b00, 1'b0, "R6");
      idle(1'b0, "R6");
      // R7: bad write to word 0 dropped, error window raised
      step(1'b1, 16'h0003, 3'd0, 3'b000, 2'b00, 1'b1, "R7");
      idle(1'b0, "R7");
      idle(1'b0, "R7");
      idle(1'b0, "R7");
      // R3 with R6: bad DRAM command, then good write while window open
      step(1'b1, 16'h4444, 3'd4, 3'b011, 2'b00, 1'b1, "R3");
      step(1'b1, 16'h000E, 3'd1, 3'b000, 2'b00, 1'b0, "R6");
      idle(1'b0, "R3");
      idle(1'b0, "R3");
      // R3: bad command then bad write restarts window; write dropped (R7)
      step(1'b1, 16'h2222, 3'd2, 3'b101, 2'b01, 1'b1, "R3");
      step(1'b1, 16'h0011, 3'd6, 3'b000, 2'b00, 1'b1, "R7");
      idle(1'b0, "R3");
      idle(1'b0, "R3");
      idle(1'b0, "R3");
      idle(1'b0, "R3");
      // R9: reset mid-stream while an error window is open
      step(1'b1, 16'h7777, 3'd3, 3'b001, 2'b10, 1'b1, "R5");
      step(1'b0, 16'h0000, 3'd0, 3'b111, 2'b11, 1'b0, "R9");
      idle(1'b0, "R9");
      idle(1'b0, "R9");
      @(posedge clk);
      #2;
      while (exp_q.size() > 0) begin
         @(posedge clk);
         #2;
      end
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule